// File: doc/BRIEF.md
# Audio Serial Port Control and Status Unit

This block is the register face of a stereo or time-division-multiplexed audio serial port. A simple single-cycle register bus reaches a small set of 32-bit word-aligned registers. Through them software turns the receiver, the transmitter and the bit-clock generator on and off, programs a mode word that the serializer consumes, watches the port's health through a status word, and chooses which status events raise the single level-sensitive interrupt.

The serializer talks to the block with event pulses. A received word arrives with its channel number. A transmit slot asks for the next word, also with its channel number. The block keeps one receive holding word and one transmit holding word. It latches a receive overrun when a new word lands on an unread one, and a transmit underrun when a slot finds the holding word empty. Each such event is recorded both as a summary flag and as a per-channel flag. Enables are driven by separate turn-on and turn-off command bits. Event flags are cleared and set through separate write-one registers. A software-reset command returns the control state to idle in one cycle.

Top module: `aud_port_csr`

## Requirements
- R1: After reset, all three enable outputs and `irq` are 0, and the status and mask registers read 0. The identification register at byte offset 0x28 reads the `VERSION` parameter (default 0x0000_0142).
- R2: A write to the command register (offset 0x00) acts on the listed bits and is otherwise write-only. Bit 0 turns the receiver on and bit 1 turns it off. Bit 2 turns the clock on and bit 3 turns it off. Bit 4 turns the transmitter on and bit 5 turns it off. Each change shows on `rx_en`, `ck_en` and `tx_en` right after the write's clock edge, and a bit written as 0 changes nothing.
- R3: When a turn-on bit and its matching turn-off bit are both 1 in one write, the enable ends up 0.
- R4: The status register (offset 0x08) reads as follows. Bit 0 is the receiver enable and bit 1 is receive-ready. Bit 2 is the overrun summary. Bit 4 is the transmitter enable and bit 5 is transmit-ready, which means the transmitter is enabled and the transmit holding word is empty. Bit 6 is the underrun summary. Bits 8+n hold the overrun flag of channel n and bits 20+n hold the underrun flag of channel n, for n from 0 to 7.
- R5: While the receiver is enabled, an `rx_push` captures `rx_data` and sets receive-ready. A push that finds receive-ready already set, with no holding-register read in the same cycle, sets the overrun summary and the overrun flag of channel `rx_ch`, and the new word replaces the old one. A push while the receiver is disabled changes nothing.
- R6: A read of the receive holding register (offset 0x20) returns the captured word and clears receive-ready. If a push happens in the same cycle as that read, receive-ready stays set and no overrun is recorded.
- R7: A write to the transmit holding register (offset 0x24) loads `tx_data` and marks the holding word full. While the transmitter is enabled, a `tx_pull` empties a full holding word. A `tx_pull` on an empty holding word sets the underrun summary and the underrun flag of channel `tx_ch`.
- R8: Writing 1 to a bit of the flag-clear register (offset 0x0C) clears that event flag. Writing 1 to a bit of the flag-force register (offset 0x10) sets it. Only the event flags are affected: bits 2, 6, 15:8 and 27:20. If a datapath event and a clear hit the same flag in the same cycle, the flag ends up set.
- R9: Writing 1s to the source-enable register (0x14) sets mask bits, and writing 1s to the source-disable register (0x18) clears them. The mask reads back at 0x1C. Only mask bits 1, 2, 5 and 6 exist; the others read 0.
- R10: `irq` is high exactly when some status bit and its mask bit are both 1. With the default `IRQ_REG`=1 it follows a state change one clock later.
- R11: A command write with bit 7 set wins over every other bit of that write. It clears all enables, the event flags, receive-ready, the transmit holding state, the mask and `irq` in one cycle. The mode register keeps its value.
- R12: The mode register (offset 0x04) stores a write ANDed with `MODE_WMASK` (default 0xFF3F_77DD), reads back that value, and drives it on `mode_bits`.
- R13: Every read returns `bus_rvalid` one cycle later. A misaligned or unmapped access reads 0 and a write to it is ignored. Writes to the status, mask and identification registers are ignored, and the command, clear, force, enable, disable and transmit holding registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| rx_push | input | 1 | Serializer delivers a received word |
| rx_ch | input | CH_W | Channel of the received word |
| rx_data | input | DATA_W | Received word |
| tx_pull | input | 1 | Serializer takes the transmit word |
| tx_ch | input | CH_W | Channel of the transmit slot |
| tx_data | output | DATA_W | Transmit holding word |
| rx_en | output | 1 | Receiver enable level |
| tx_en | output | 1 | Transmitter enable level |
| ck_en | output | 1 | Clock generator enable level |
| mode_bits | output | 32 | Mode register contents |
| irq | output | 1 | Level interrupt |

## Verification
Nearly every internal error surfaces on the next status read or at the enable pins, one cycle after the write or event that caused it. A wrong channel decode shows as a misplaced bit in 15:8 or 27:20, and a lost priority rule shows as a flag or enable whose value is opposite to the one expected. Mask faults show on `irq` one clock after the triggering change, so the bench reads `irq` both immediately after a mask write and one cycle later. Side effects such as the holding-register read clearing receive-ready are only visible on a later status read, so the bench reads the status back after each of them.

// File: rtl/aud_csr_pkg.sv
package aud_csr_pkg;

   localparam int BUS_W      = 32;
   localparam int MAX_CH     = 8;

   // status word positions
   localparam int ST_RX_EN   = 0;
   localparam int ST_RX_RDY  = 1;
   localparam int ST_RX_OVR  = 2;
   localparam int ST_TX_EN   = 4;
   localparam int ST_TX_RDY  = 5;
   localparam int ST_TX_UND  = 6;
   localparam int OVR_CH_LSB = 8;
   localparam int UND_CH_LSB = 20;

   // command word: pair i uses bit 2i (on) and 2i+1 (off)
   localparam int CMD_PAIRS  = 3;
   localparam int CMD_RESET  = 7;

   // status bits that may raise the interrupt
   localparam logic [BUS_W-1:0] IRQ_SRC_MASK = 32'h0000_0066;

   typedef enum logic [3:0] {
      REG_CMD   = 4'd0,
      REG_MODE  = 4'd1,
      REG_STAT  = 4'd2,
      REG_FCLR  = 4'd3,
      REG_FSET  = 4'd4,
      REG_SRCON = 4'd5,
      REG_SRCOF = 4'd6,
      REG_SRCMK = 4'd7,
      REG_RXH   = 4'd8,
      REG_TXH   = 4'd9,
      REG_IDENT = 4'd10,
      REG_NONE  = 4'd15
   } csr_reg_e;

endpackage

// File: rtl/aud_csr_decode.sv
module aud_csr_decode
   import aud_csr_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output csr_reg_e          reg_sel,
   output logic              wr_acc,
   output logic              rd_acc
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] word_idx;
   logic             aligned;

   assign word_idx = bus_addr[ADDR_W-1:2];
   assign aligned  = (bus_addr[1:0] == 2'b00);
   assign wr_acc   = bus_sel & bus_wr;
   assign rd_acc   = bus_sel & ~bus_wr;

   always_comb begin
      reg_sel = REG_NONE;
      if (aligned && (word_idx <= IDX_W'(REG_IDENT))) begin
         reg_sel = csr_reg_e'(word_idx[3:0]);
      end
   end

endmodule

// File: rtl/aud_csr_enables.sv
module aud_csr_enables
   import aud_csr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_wr,
   input  logic [7:0] cmd_bits,
   output logic       rx_en,
   output logic       ck_en,
   output logic       tx_en,
   output logic       soft_rst
);
   logic [CMD_PAIRS-1:0] en_vec;

   assign soft_rst = cmd_wr & cmd_bits[CMD_RESET];

   generate
      for (genvar i = 0; i < CMD_PAIRS; i++) begin : g_pair
         logic on_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               on_q <= 1'b0;
            end else if (soft_rst) begin
               on_q <= 1'b0;
            end else if (cmd_wr && cmd_bits[2*i+1]) begin
               on_q <= 1'b0;
            end else if (cmd_wr && cmd_bits[2*i]) begin
               on_q <= 1'b1;
            end
         end
         assign en_vec[i] = on_q;
      end
   endgenerate

   assign rx_en = en_vec[0];
   assign ck_en = en_vec[1];
   assign tx_en = en_vec[2];

   logic unused_cmd;
   assign unused_cmd = cmd_bits[6];

endmodule

// File: rtl/aud_csr_status.sv
module aud_csr_status
   import aud_csr_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              rx_en,
   input  logic              tx_en,
   input  logic              rx_push,
   input  logic [CH_W-1:0]   rx_ch,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              tx_pull,
   input  logic [CH_W-1:0]   tx_ch,
   input  logic              rxh_rd,
   input  logic              txh_wr,
   input  logic              fclr_wr,
   input  logic              fset_wr,
   input  logic [BUS_W-1:0]  wdata,
   output logic              rx_rdy,
   output logic              tx_full,
   output logic [DATA_W-1:0] rx_word,
   output logic [DATA_W-1:0] tx_word,
   output logic              ovr_sum,
   output logic              und_sum,
   output logic [NUM_CH-1:0] ovr_vec,
   output logic [NUM_CH-1:0] und_vec
);
   logic              rx_evt, ovr_evt, und_evt;
   logic [BUS_W-1:0]  clr_bits, set_bits;

   assign rx_evt   = rx_push & rx_en;
   assign ovr_evt  = rx_evt & rx_rdy & ~rxh_rd;
   assign und_evt  = tx_pull & tx_en & ~tx_full;
   assign clr_bits = fclr_wr ? wdata : '0;
   assign set_bits = fset_wr ? wdata : '0;

   // receive holding word and ready flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_rdy  <= 1'b0;
         rx_word <= '0;
      end else if (soft_rst) begin
         rx_rdy  <= 1'b0;
      end else if (rx_evt) begin
         rx_rdy  <= 1'b1;
         rx_word <= rx_data;
      end else if (rxh_rd) begin
         rx_rdy  <= 1'b0;
      end
   end

   // transmit holding word and occupancy
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_full <= 1'b0;
         tx_word <= '0;
      end else if (soft_rst) begin
         tx_full <= 1'b0;
      end else if (txh_wr) begin
         tx_full <= 1'b1;
         tx_word <= wdata[DATA_W-1:0];
      end else if (tx_pull && tx_en) begin
         tx_full <= 1'b0;
      end
   end

   // summary flags: an event outranks a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_sum <= 1'b0;
         und_sum <= 1'b0;
      end else if (soft_rst) begin
         ovr_sum <= 1'b0;
         und_sum <= 1'b0;
      end else begin
         if (ovr_evt || set_bits[ST_RX_OVR])      ovr_sum <= 1'b1;
         else if (clr_bits[ST_RX_OVR])            ovr_sum <= 1'b0;
         if (und_evt || set_bits[ST_TX_UND])      und_sum <= 1'b1;
         else if (clr_bits[ST_TX_UND])            und_sum <= 1'b0;
      end
   end

   // per-channel flags
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         logic ovr_q, und_q, ovr_hit, und_hit;
         assign ovr_hit = ovr_evt && (rx_ch == CH_W'(c));
         assign und_hit = und_evt && (tx_ch == CH_W'(c));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ovr_q <= 1'b0;
               und_q <= 1'b0;
            end else if (soft_rst) begin
               ovr_q <= 1'b0;
               und_q <= 1'b0;
            end else begin
               if (ovr_hit || set_bits[OVR_CH_LSB+c])  ovr_q <= 1'b1;
               else if (clr_bits[OVR_CH_LSB+c])        ovr_q <= 1'b0;
               if (und_hit || set_bits[UND_CH_LSB+c])  und_q <= 1'b1;
               else if (clr_bits[UND_CH_LSB+c])        und_q <= 1'b0;
            end
         end
         assign ovr_vec[c] = ovr_q;
         assign und_vec[c] = und_q;
      end
   endgenerate

   logic unused_wd;
   assign unused_wd = ^wdata;

endmodule

// File: rtl/aud_csr_irq.sv
module aud_csr_irq
   import aud_csr_pkg::*;
#(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             src_on_wr,
   input  logic             src_off_wr,
   input  logic [BUS_W-1:0] wdata,
   input  logic [BUS_W-1:0] status,
   output logic [BUS_W-1:0] mask,
   output logic             irq
);
   logic [BUS_W-1:0] mask_nxt;
   logic             hit;

   assign mask_nxt = (mask | (src_on_wr ? wdata : '0))
                   & ~(src_off_wr ? wdata : '0)
                   & IRQ_SRC_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask <= '0;
      else if (soft_rst) mask <= '0;
      else               mask <= mask_nxt;
   end

   assign hit = |(status & mask);

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        irq_q <= 1'b0;
            else if (soft_rst) irq_q <= 1'b0;
            else               irq_q <= hit;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = hit;
      end
   endgenerate

endmodule

// File: rtl/aud_port_csr.sv
module aud_port_csr
   import aud_csr_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          NUM_CH     = 8,
   parameter int          DATA_W     = 32,
   parameter bit          IRQ_REG    = 1'b1,
   parameter logic [31:0] VERSION    = 32'h0000_0142,
   parameter logic [31:0] MODE_WMASK = 32'hFF3F_77DD,
   localparam int         CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic              bus_rvalid,
   output logic [31:0]       bus_rdata,
   input  logic              rx_push,
   input  logic [CH_W-1:0]   rx_ch,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              tx_pull,
   input  logic [CH_W-1:0]   tx_ch,
   output logic [DATA_W-1:0] tx_data,
   output logic              rx_en,
   output logic              tx_en,
   output logic              ck_en,
   output logic [31:0]       mode_bits,
   output logic              irq
);
   // elaboration checks
   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("aud_port_csr: ADDR_W must be at least 6");
      end
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
         $error("aud_port_csr: NUM_CH must be 1..8");
      end
      if (DATA_W < 1 || DATA_W > BUS_W) begin : g_bad_data
         $error("aud_port_csr: DATA_W must be 1..32");
      end
   endgenerate

   csr_reg_e          reg_sel;
   logic              wr_acc, rd_acc, soft_rst;
   logic              rx_rdy_s, tx_full_s, ovr_sum, und_sum;
   logic [NUM_CH-1:0] ovr_vec, und_vec;
   logic [DATA_W-1:0] rx_word;
   logic [BUS_W-1:0]  stat_word, mask_q, rd_val, mode_q;
   logic              rxh_rd;

   aud_csr_decode #(.ADDR_W(ADDR_W)) i_decode (
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .reg_sel  (reg_sel),
      .wr_acc   (wr_acc),
      .rd_acc   (rd_acc)
   );

   aud_csr_enables i_enables (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (wr_acc && reg_sel == REG_CMD),
      .cmd_bits (bus_wdata[7:0]),
      .rx_en    (rx_en),
      .ck_en    (ck_en),
      .tx_en    (tx_en),
      .soft_rst (soft_rst)
   );

   assign rxh_rd = rd_acc && (reg_sel == REG_RXH);

   aud_csr_status #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W)) i_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .rx_en    (rx_en),
      .tx_en    (tx_en),
      .rx_push  (rx_push),
      .rx_ch    (rx_ch),
      .rx_data  (rx_data),
      .tx_pull  (tx_pull),
      .tx_ch    (tx_ch),
      .rxh_rd   (rxh_rd),
      .txh_wr   (wr_acc && reg_sel == REG_TXH),
      .fclr_wr  (wr_acc && reg_sel == REG_FCLR),
      .fset_wr  (wr_acc && reg_sel == REG_FSET),
      .wdata    (bus_wdata),
      .rx_rdy   (rx_rdy_s),
      .tx_full  (tx_full_s),
      .rx_word  (rx_word),
      .tx_word  (tx_data),
      .ovr_sum  (ovr_sum),
      .und_sum  (und_sum),
      .ovr_vec  (ovr_vec),
      .und_vec  (und_vec)
   );

   always_comb begin
      stat_word            = '0;
      stat_word[ST_RX_EN]  = rx_en;
      stat_word[ST_RX_RDY] = rx_rdy_s;
      stat_word[ST_RX_OVR] = ovr_sum;
      stat_word[ST_TX_EN]  = tx_en;
      stat_word[ST_TX_RDY] = tx_en & ~tx_full_s;
      stat_word[ST_TX_UND] = und_sum;
      for (int c = 0; c < NUM_CH; c++) begin
         stat_word[OVR_CH_LSB+c] = ovr_vec[c];
         stat_word[UND_CH_LSB+c] = und_vec[c];
      end
   end

   aud_csr_irq #(.IRQ_REG(IRQ_REG)) i_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .src_on_wr  (wr_acc && reg_sel == REG_SRCON),
      .src_off_wr (wr_acc && reg_sel == REG_SRCOF),
      .wdata      (bus_wdata),
      .status     (stat_word),
      .mask       (mask_q),
      .irq        (irq)
   );

   // mode register (kept across software reset)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                mode_q <= '0;
      else if (wr_acc && reg_sel == REG_MODE)    mode_q <= bus_wdata & MODE_WMASK;
   end
   assign mode_bits = mode_q;

   // read path
   always_comb begin
      rd_val = '0;
      unique case (reg_sel)
         REG_MODE:  rd_val = mode_q;
         REG_STAT:  rd_val = stat_word;
         REG_SRCMK: rd_val = mask_q;
         REG_RXH:   rd_val[DATA_W-1:0] = rx_word;
         REG_IDENT: rd_val = VERSION;
         default:   rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= rd_acc;
         if (rd_acc) bus_rdata <= rd_val;
      end
   end

endmodule

// File: rtl/aud_port_csr_chk.sv
module aud_port_csr_chk #(
   parameter int ADDR_W  = 8,
   parameter int NUM_CH  = 8,
   parameter int CH_W    = 3,
   parameter bit IRQ_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              bus_rvalid,
   input logic [31:0]       bus_rdata,
   input logic              rx_push,
   input logic [CH_W-1:0]   rx_ch,
   input logic              tx_pull,
   input logic [CH_W-1:0]   tx_ch,
   input logic              rx_en,
   input logic              tx_en,
   input logic              ck_en,
   input logic              irq,
   input logic              rx_rdy_s,
   input logic              tx_full_s,
   input logic [NUM_CH-1:0] ovr_vec,
   input logic [NUM_CH-1:0] und_vec,
   input logic [31:0]       mask_q
);
   logic cmd_wr, rst_cmd, rxh_read;

   assign cmd_wr   = bus_sel && bus_wr && (bus_addr == ADDR_W'(0));
   assign rst_cmd  = cmd_wr && bus_wdata[7];
   assign rxh_read = bus_sel && !bus_wr && (bus_addr == ADDR_W'(32));

   AST_RX_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && bus_wdata[1] |=> !rx_en);  // R3

   AST_TX_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && bus_wdata[5] |=> !tx_en);  // R3

   AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      rst_cmd |=> !rx_en && !tx_en && !ck_en && !irq && mask_q == 32'd0
                  && !rx_rdy_s && !tx_full_s);  // R11

   AST_RX_OVR_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push && rx_en && rx_rdy_s && !rxh_read && !rst_cmd
      && (int'(rx_ch) < NUM_CH) |=> ovr_vec[$past(rx_ch)]);  // R5

   AST_TX_UND_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pull && tx_en && !tx_full_s && !rst_cmd
      && (int'(tx_ch) < NUM_CH) |=> und_vec[$past(tx_ch)]);  // R7

   AST_RX_RDY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      rxh_read && !rx_push |=> !rx_rdy_s);  // R6

   AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (IRQ_REG ? ($past(mask_q) != 32'd0) : (mask_q != 32'd0)));  // R10

   AST_BAD_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel && !bus_wr && bus_addr[1:0] != 2'b00 |=> bus_rvalid && bus_rdata == 32'd0);  // R13

endmodule

bind aud_port_csr aud_port_csr_chk #(
   .ADDR_W  (ADDR_W),
   .NUM_CH  (NUM_CH),
   .CH_W    (CH_W),
   .IRQ_REG (IRQ_REG)
) i_aud_port_csr_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rvalid (bus_rvalid),
   .bus_rdata  (bus_rdata),
   .rx_push    (rx_push),
   .rx_ch      (rx_ch),
   .tx_pull    (tx_pull),
   .tx_ch      (tx_ch),
   .rx_en      (rx_en),
   .tx_en      (tx_en),
   .ck_en      (ck_en),
   .irq        (irq),
   .rx_rdy_s   (rx_rdy_s),
   .tx_full_s  (tx_full_s),
   .ovr_vec    (ovr_vec),
   .und_vec    (und_vec),
   .mask_q     (mask_q)
);

// File: tb/test_aud_port_csr.sv
module test_aud_port_csr;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG       = 20000;

   localparam logic [7:0] A_CMD = 8'h00, A_MODE = 8'h04, A_STAT = 8'h08,
                          A_FCLR = 8'h0C, A_FSET = 8'h10, A_SON = 8'h14,
                          A_SOFF = 8'h18, A_SMSK = 8'h1C, A_RXH = 8'h20,
                          A_TXH = 8'h24, A_ID = 8'h28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rvalid;
   logic [31:0] bus_rdata;
   logic        rx_push = 1'b0, tx_pull = 1'b0;
   logic [2:0]  rx_ch = '0, tx_ch = '0;
   logic [31:0] rx_data = '0;
   logic [31:0] tx_data;
   logic        rx_en, tx_en, ck_en, irq;
   logic [31:0] mode_bits;

   int checks = 0;
   int failures = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   aud_port_csr i_aud_port_csr (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
      .bus_rdata(bus_rdata), .rx_push(rx_push), .rx_ch(rx_ch),
      .rx_data(rx_data), .tx_pull(tx_pull), .tx_ch(tx_ch), .tx_data(tx_data),
      .rx_en(rx_en), .tx_en(tx_en), .ck_en(ck_en), .mode_bits(mode_bits),
      .irq(irq)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data as results appear
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL R13 unexpected read data actual=%h expected=none", bus_rdata);
         end else begin
            chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      @(negedge clk); exp_q.push_back(e); tag_q.push_back(tag);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      @(negedge clk); bus_sel = 0;
   endtask

   task automatic push_rx(input logic [2:0] ch, input logic [31:0] d);
      @(negedge clk); rx_push = 1; rx_ch = ch; rx_data = d;
      @(negedge clk); rx_push = 0;
   endtask

   task automatic pull_tx(input logic [2:0] ch);
      @(negedge clk); tx_pull = 1; tx_ch = ch;
      @(negedge clk); tx_pull = 0;
   endtask

   task automatic rd_with_push(input logic [31:0] e, input string tag,
                               input logic [2:0] ch, input logic [31:0] d);
      @(negedge clk); exp_q.push_back(e); tag_q.push_back(tag);
      bus_sel = 1; bus_wr = 0; bus_addr = A_RXH;
      rx_push = 1; rx_ch = ch; rx_data = d;
      @(negedge clk); bus_sel = 0; rx_push = 0;
   endtask

   task automatic wr_with_pull(input logic [7:0] a, input logic [31:0] d, input logic [2:0] ch);
      @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      tx_pull = 1; tx_ch = ch;
      @(negedge clk); bus_sel = 0; bus_wr = 0; tx_pull = 0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk({29'd0, rx_en, tx_en, ck_en}, 32'd0, "R1 enables after reset");
      chk({31'd0, irq}, 32'd0, "R1 irq after reset");
      rd(A_STAT, 32'h0, "R1 status after reset");
      rd(A_SMSK, 32'h0, "R1 mask after reset");
      rd(A_ID, 32'h0000_0142, "R1 identification");

      // R2 command bits
      wr(A_CMD, 32'h15);
      chk({29'd0, rx_en, ck_en, tx_en}, 32'h7, "R2 all enables on");
      rd(A_STAT, 32'h31, "R4 status layout with enables");
      rd(A_CMD, 32'h0, "R13 command reads zero");
      wr(A_CMD, 32'h02);
      chk({29'd0, rx_en, ck_en, tx_en}, 32'h3, "R2 receiver off only");
      wr(A_CMD, 32'h00);
      chk({29'd0, rx_en, ck_en, tx_en}, 32'h3, "R2 zero write no effect");

      // R3 off wins
      wr(A_CMD, 32'h01);
      chk({31'd0, rx_en}, 32'h1, "R2 receiver on");
      wr(A_CMD, 32'h03);
      chk({31'd0, rx_en}, 32'h0, "R3 rx on+off");
      wr(A_CMD, 32'h30);
      chk({31'd0, tx_en}, 32'h0, "R3 tx on+off");
      wr(A_CMD, 32'h0C);
      chk({31'd0, ck_en}, 32'h0, "R3 clk on+off");
      wr(A_CMD, 32'h15);

      // R5 receive capture and overrun
      push_rx(3'd0, 32'hA5A5_0001);
      rd(A_STAT, 32'h33, "R5 receive ready set");
      push_rx(3'd3, 32'hA5A5_0002);
      rd(A_STAT, 32'h837, "R5 overrun on channel 3");
      rd(A_RXH, 32'hA5A5_0002, "R5 newest word kept");
      rd(A_STAT, 32'h835, "R6 read clears ready");
      wr(A_CMD, 32'h02);
      push_rx(3'd5, 32'hDEAD_0005);
      rd(A_STAT, 32'h834, "R5 push ignored while disabled");
      rd(A_RXH, 32'hA5A5_0002, "R5 holding unchanged while disabled");
      wr(A_CMD, 32'h01);

      // R6 read and push together
      push_rx(3'd0, 32'h0000_00D3);
      rd_with_push(32'h0000_00D3, "R6 read returns old word", 3'd1, 32'h0000_00D4);
      rd(A_STAT, 32'h837, "R6 ready kept no overrun ch1");
      rd(A_RXH, 32'h0000_00D4, "R6 new word after joint cycle");

      // R8 clear and force
      wr(A_FCLR, 32'h804);
      rd(A_STAT, 32'h31, "R8 clear overrun flags");
      wr(A_FCLR, 32'h31);
      rd(A_STAT, 32'h31, "R8 clear leaves other bits");
      wr(A_FSET, 32'h0010_0040);
      rd(A_STAT, 32'h0010_0071, "R8 force underrun ch0");
      wr(A_FCLR, 32'h0FF0_FF44);
      rd(A_STAT, 32'h31, "R8 clear all flags");

      // R7 transmit side
      wr(A_TXH, 32'h0000_CAFE);
      chk(tx_data, 32'h0000_CAFE, "R7 transmit word loaded");
      rd(A_STAT, 32'h11, "R7 transmit ready low when full");
      pull_tx(3'd2);
      rd(A_STAT, 32'h31, "R7 pull empties no underrun");
      pull_tx(3'd6);
      rd(A_STAT, 32'h0400_0071, "R7 underrun channel 6");
      wr_with_pull(A_FCLR, 32'h0400_0040, 3'd6);
      rd(A_STAT, 32'h0400_0071, "R8 event beats clear");
      wr(A_FCLR, 32'h0FF0_FF44);
      rd(A_STAT, 32'h31, "R8 flags cleared again");

      // R9 / R10 mask and interrupt
      wr(A_SON, 32'h44);
      @(negedge clk);
      chk({31'd0, irq}, 32'h0, "R10 masked sources idle");
      rd(A_SMSK, 32'h44, "R9 mask set bits");
      wr(A_SON, 32'hFFFF_FFFF);
      rd(A_SMSK, 32'h66, "R9 only implemented mask bits");
      chk({31'd0, irq}, 32'h1, "R10 transmit ready raises irq");
      wr(A_SOFF, 32'h20);
      chk({31'd0, irq}, 32'h1, "R10 irq one cycle latency");
      @(negedge clk);
      chk({31'd0, irq}, 32'h0, "R10 irq drops after disable");
      rd(A_SMSK, 32'h46, "R9 mask bit cleared");
      push_rx(3'd0, 32'h0000_0077);
      @(negedge clk);
      chk({31'd0, irq}, 32'h1, "R10 receive ready irq");
      rd(A_RXH, 32'h0000_0077, "R6 read word for irq");
      @(negedge clk);
      chk({31'd0, irq}, 32'h0, "R10 irq clears after read");

      // R12 mode register
      wr(A_MODE, 32'hFFFF_FFFF);
      rd(A_MODE, 32'hFF3F_77DD, "R12 mode reserved bits zero");
      chk(mode_bits, 32'hFF3F_77DD, "R12 mode output");

      // R13 ignored accesses
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, 32'h31, "R13 status write ignored");
      wr(8'h2C, 32'hFFFF_FFFF);
      rd(8'h2C, 32'h0, "R13 unmapped reads zero");
      wr(8'h05, 32'h0);
      rd(A_MODE, 32'hFF3F_77DD, "R13 misaligned write ignored");
      rd(8'h06, 32'h0, "R13 misaligned read zero");
      wr(A_SMSK, 32'h0);
      rd(A_SMSK, 32'h46, "R13 mask register read-only");
      wr(A_ID, 32'h0);
      rd(A_ID, 32'h0000_0142, "R13 identification read-only");
      rd(A_TXH, 32'h0, "R13 transmit holding reads zero");

      // R11 software reset
      wr(A_FSET, 32'h04);
      @(negedge clk);
      chk({31'd0, irq}, 32'h1, "R11 irq pending before reset");
      wr(A_CMD, 32'h95);
      chk({28'd0, rx_en, ck_en, tx_en, irq}, 32'h0, "R11 reset beats enables");
      rd(A_STAT, 32'h0, "R11 status cleared");
      rd(A_SMSK, 32'h0, "R11 mask cleared");
      rd(A_MODE, 32'hFF3F_77DD, "R11 mode kept");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; failures++;
         $display("FAIL R13 missing read data actual=%0d expected=0", exp_q.size());
      end
      summary();
      $finish;
   end

endmodule